// File: doc/BRIEF.md
# Per-Core Power Domain Sequencer

This block brings each processor core of a small cluster into or out of power by walking a fixed list of control-bit changes. Each core has a seven-bit control word and a separate L1 power-down request. The word drives the core's two power switches, its isolation, its clock gate, its reset, and the clock and data isolation of its SRAM. Between some steps the sequencer waits for an acknowledge input or for a fixed delay. A wait that is not met in time ends the sequence with an error, and every output is left as it was at that moment.

Software first unlocks the block with a keyed write. It then issues a request that names the core, the direction, and for power-down whether to wait until the core reports idle. Only one core is sequenced at a time. `busy` covers the whole sequence. `done` or `err` pulses at its end. The delay and poll timing is set by a cycles-per-microsecond parameter.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core's word is 0x32 (bit0 reset release 0, bit1 isolation 1, bit2 primary switch 0, bit3 secondary switch 0, bit4 clock disable 1, bit5 SRAM clock isolation 1, bit6 active-low SRAM isolation 0). Every `l1_pdn` bit is 1 and `busy`, `done` and `err` are 0.
- R2: A request is accepted only while the enable is set. A key write sets the enable when `key_code` is 0x0B16 and `key_set` is 1, and clears it for any other combination. A request made while the enable is clear leaves `busy` low and every output unchanged.
- R3: Power-up changes one bit per cycle, in this order: set bit2, set bit3, clear bit1, clear `l1_pdn`, set bit6, clear bit5, clear bit4, set bit0. It ends with the word 0x4D and `l1_pdn` at 0.
- R4: During power-up, bit3 rises exactly CYC_PER_US+1 cycles after bit2.
- R5: The switch waits need both status inputs of the core to agree: `pwr_ok` and `pwr_ok2` both high after power-up switching, both low after power-down switching.
- R6: Power-down changes one bit per cycle, in this order: set bit1, set bit5, clear bit6, set `l1_pdn`, clear bit0, set bit4, clear bit2, clear bit3. It then waits for both status inputs to be low and ends with 0x32.
- R7: After setting `l1_pdn` the sequence waits for `l1_ack` high. After clearing it, the sequence waits for `l1_ack` low.
- R8: A wait that stays unmet for POLLS*CYC_PER_US cycles ends the sequence. `err` then pulses for one cycle, `busy` falls, and all outputs hold their values.
- R9: With the wait-for-idle option on a power-down, the sequencer first waits for `core_idle` of that core within the same window. On a timeout it raises `err` and changes no control bit.
- R10: Only the addressed core's outputs change. A request made while `busy` is high is ignored. Outputs never change while idle.
- R11: `busy` is high from the cycle after acceptance until the cycle in which `done` or `err` appears. `done` pulses for exactly one cycle when a sequence succeeds.
- R12: On every core, these hold at all times: isolation is released only while both switches are on, the clock is enabled only while both switches are on, and reset is released only while the clock is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| key_wr | input | 1 | Enable register write strobe |
| key_code | input | 16 | Key value written with the strobe |
| key_set | input | 1 | Enable bit written with the strobe |
| req_valid | input | 1 | Sequence request strobe |
| req_core | input | CW (2) | Core index of the request |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_wait_idle | input | 1 | Power-down waits for core idle first |
| pwr_ok | input | NCORE | Primary power-status ack per core |
| pwr_ok2 | input | NCORE | Secondary power-status ack per core |
| l1_ack | input | NCORE | L1 power-down ack per core |
| core_idle | input | NCORE | Core idle indication per core |
| core_ctl | output | 7*NCORE | Control words, core n at bits 7n+6..7n |
| l1_pdn | output | NCORE | L1 power-down request per core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on timeout |

## Verification
`busy` is due one clock edge after the request edge. After that the control bits change one per cycle. The only gaps are the CYC_PER_US-cycle delays, which place bit3 CYC_PER_US+1 cycles after bit2, and the waits. `done` or `err` appears in the cycle after the final step or timeout edge and is gone one cycle later. A timed-out switch wait raises `err` exactly POLLS*CYC_PER_US cycles after the bit that opened it. The bench drives inputs and samples outputs on falling edges. It logs every bit change of the active core with its cycle number, so both the order and these distances are checked at those exact cycles.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int NCORE = 4,
  parameter int CYC_PER_US = 250,
  parameter int POLLS = 10,
  parameter logic [15:0] KEY = 16'h0B16,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_wr,
  input  logic [15:0]        key_code,
  input  logic               key_set,
  input  logic               req_valid,
  input  logic [CW-1:0]      req_core,
  input  logic               req_on,
  input  logic               req_wait_idle,
  input  logic [NCORE-1:0]   pwr_ok,
  input  logic [NCORE-1:0]   pwr_ok2,
  input  logic [NCORE-1:0]   l1_ack,
  input  logic [NCORE-1:0]   core_idle,
  output logic [7*NCORE-1:0] core_ctl,
  output logic [NCORE-1:0]   l1_pdn,
  output logic               busy,
  output logic               done,
  output logic               err
);
  localparam int TMO = POLLS * CYC_PER_US;
  localparam int TW = $clog2(TMO + 1);
  localparam logic [6:0] OFF_WORD = 7'h32;

  typedef enum logic [4:0] {
    S_IDLE, S_ON_P1, S_ON_D1, S_ON_P2, S_ON_WP, S_ON_ISO, S_ON_L1, S_ON_WL1,
    S_ON_D2, S_ON_SRB, S_ON_CKI, S_ON_CLK, S_ON_RST,
    S_OF_WID, S_OF_ISO, S_OF_CKI, S_OF_SRB, S_OF_L1, S_OF_WL1, S_OF_RST,
    S_OF_CLK, S_OF_P1, S_OF_P2, S_OF_WP
  } st_t;

  st_t st;
  logic key_ok;
  logic [CW-1:0] sel;
  logic [TW-1:0] tcnt;
  logic [6:0] ctl [NCORE];
  logic both_on, both_off, dly_end, tmo_end, go;

  assign both_on  = pwr_ok[sel] & pwr_ok2[sel];
  assign both_off = ~pwr_ok[sel] & ~pwr_ok2[sel];
  assign dly_end  = tcnt == TW'(CYC_PER_US - 1);
  assign tmo_end  = tcnt == TW'(TMO - 1);
  assign go       = req_valid & key_ok & (st == S_IDLE);
  assign busy     = st != S_IDLE;

  for (genvar g = 0; g < NCORE; g++) begin : g_out
    assign core_ctl[g*7 +: 7] = ctl[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) key_ok <= 1'b0;
    else if (key_wr) key_ok <= (key_code == KEY) & key_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sel <= '0;
      tcnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      l1_pdn <= '1;
      for (int i = 0; i < NCORE; i++) ctl[i] <= OFF_WORD;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          sel <= req_core;
          tcnt <= '0;
          st <= req_on ? S_ON_P1 : (req_wait_idle ? S_OF_WID : S_OF_ISO);
        end
        S_ON_P1: begin ctl[sel][2] <= 1'b1; st <= S_ON_D1; end
        S_ON_D1:
          if (dly_end) begin tcnt <= '0; st <= S_ON_P2; end
          else tcnt <= tcnt + 1'b1;
        S_ON_P2: begin ctl[sel][3] <= 1'b1; st <= S_ON_WP; end
        S_ON_WP:
          if (both_on) begin tcnt <= '0; st <= S_ON_ISO; end
          else if (tmo_end) begin err <= 1'b1; st <= S_IDLE; end
          else tcnt <= tcnt + 1'b1;
        S_ON_ISO: begin ctl[sel][1] <= 1'b0; st <= S_ON_L1; end
        S_ON_L1:  begin l1_pdn[sel] <= 1'b0; st <= S_ON_WL1; end
        S_ON_WL1:
          if (!l1_ack[sel]) begin tcnt <= '0; st <= S_ON_D2; end
          else if (tmo_end) begin err <= 1'b1; st <= S_IDLE; end
          else tcnt <= tcnt + 1'b1;
        S_ON_D2:
          if (dly_end) begin tcnt <= '0; st <= S_ON_SRB; end
          else tcnt <= tcnt + 1'b1;
        S_ON_SRB: begin ctl[sel][6] <= 1'b1; st <= S_ON_CKI; end
        S_ON_CKI: begin ctl[sel][5] <= 1'b0; st <= S_ON_CLK; end
        S_ON_CLK: begin ctl[sel][4] <= 1'b0; st <= S_ON_RST; end
        S_ON_RST: begin ctl[sel][0] <= 1'b1; done <= 1'b1; st <= S_IDLE; end
        S_OF_WID:
          if (core_idle[sel]) begin tcnt <= '0; st <= S_OF_ISO; end
          else if (tmo_end) begin err <= 1'b1; st <= S_IDLE; end
          else tcnt <= tcnt + 1'b1;
        S_OF_ISO: begin ctl[sel][1] <= 1'b1; st <= S_OF_CKI; end
        S_OF_CKI: begin ctl[sel][5] <= 1'b1; st <= S_OF_SRB; end
        S_OF_SRB: begin ctl[sel][6] <= 1'b0; st <= S_OF_L1; end
        S_OF_L1:  begin l1_pdn[sel] <= 1'b1; st <= S_OF_WL1; end
        S_OF_WL1:
          if (l1_ack[sel]) begin tcnt <= '0; st <= S_OF_RST; end
          else if (tmo_end) begin err <= 1'b1; st <= S_IDLE; end
          else tcnt <= tcnt + 1'b1;
        S_OF_RST: begin ctl[sel][0] <= 1'b0; st <= S_OF_CLK; end
        S_OF_CLK: begin ctl[sel][4] <= 1'b1; st <= S_OF_P1; end
        S_OF_P1:  begin ctl[sel][2] <= 1'b0; st <= S_OF_P2; end
        S_OF_P2:  begin ctl[sel][3] <= 1'b0; st <= S_OF_WP; end
        S_OF_WP:
          if (both_off) begin tcnt <= '0; done <= 1'b1; st <= S_IDLE; end
          else if (tmo_end) begin err <= 1'b1; st <= S_IDLE; end
          else tcnt <= tcnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
  parameter int NCORE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7*NCORE-1:0] core_ctl,
  input logic [NCORE-1:0]   l1_pdn,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic               req_valid,
  input logic               key_ok
);
  logic [7*NCORE-1:0] pc;
  logic [NCORE-1:0] pl;
  logic [NCORE-1:0] chg;

  always_ff @(posedge clk) begin
    pc <= core_ctl;
    pl <= l1_pdn;
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    assign chg[g] = (core_ctl[g*7 +: 7] != pc[g*7 +: 7]) | (l1_pdn[g] != pl[g]);

    a_r12_iso_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      !core_ctl[g*7+1] |-> (core_ctl[g*7+2] && core_ctl[g*7+3]));
    a_r12_clk_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      !core_ctl[g*7+4] |-> (core_ctl[g*7+2] && core_ctl[g*7+3]));
    a_r12_run_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
      core_ctl[g*7+0] |-> !core_ctl[g*7+4]);
  end

  a_r10_one_core: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(chg));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (chg == '0));
  a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !key_ok) |=> !busy);
  a_r11_done_one: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_err_one: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
  a_r11_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_ctl(core_ctl), .l1_pdn(l1_pdn), .busy(busy),
  .done(done), .err(err), .req_valid(req_valid), .key_ok(key_ok)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  localparam int US = 8;
  localparam int TMO = 10 * US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr = 1'b0, key_set = 1'b0;
  logic [15:0] key_code = '0;
  logic req_valid = 1'b0, req_on = 1'b0, req_wait_idle = 1'b0;
  logic [1:0] req_core = '0;
  logic [3:0] pok, pok2, l1a;
  logic [3:0] idle = '0;
  logic [27:0] core_ctl;
  logic [3:0] l1_pdn;
  logic busy, done, err;

  always #2 clk = ~clk;

  core_pwr_seq #(.NCORE(4), .CYC_PER_US(US), .POLLS(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_code(key_code), .key_set(key_set),
    .req_valid(req_valid), .req_core(req_core), .req_on(req_on),
    .req_wait_idle(req_wait_idle), .pwr_ok(pok), .pwr_ok2(pok2), .l1_ack(l1a),
    .core_idle(idle), .core_ctl(core_ctl), .l1_pdn(l1_pdn), .busy(busy),
    .done(done), .err(err)
  );

  int checks = 0, fails = 0, cyc = 0;
  int lat = 2;
  bit stk1 = 0, stk2 = 0, stkl = 0;
  int act = 0;
  logic [31:0] evlog = '0;
  int evn = 0, t_p1 = 0, t_p2 = 0;
  logic [6:0] exp_w [4];
  logic exp_l [4];

  always @(posedge clk) cyc <= cyc + 1;

  // ack models: each status follows its control bit after lat cycles unless stuck
  int c1 [4], c2 [4], cl [4];
  always @(negedge clk) begin
    if (!rst_n) begin
      pok <= '0; pok2 <= '0; l1a <= '1;
      for (int n = 0; n < 4; n++) begin c1[n] <= 0; c2[n] <= 0; cl[n] <= 0; end
    end else begin
      for (int n = 0; n < 4; n++) begin
        if (!stk1 && pok[n] != core_ctl[n*7+2]) begin
          if (c1[n] >= lat) begin pok[n] <= core_ctl[n*7+2]; c1[n] <= 0; end
          else c1[n] <= c1[n] + 1;
        end else c1[n] <= 0;
        if (!stk2 && pok2[n] != core_ctl[n*7+3]) begin
          if (c2[n] >= lat) begin pok2[n] <= core_ctl[n*7+3]; c2[n] <= 0; end
          else c2[n] <= c2[n] + 1;
        end else c2[n] <= 0;
        if (!stkl && l1a[n] != l1_pdn[n]) begin
          if (cl[n] >= lat) begin l1a[n] <= l1_pdn[n]; cl[n] <= 0; end
          else cl[n] <= cl[n] + 1;
        end else cl[n] <= 0;
      end
    end
  end

  // change monitor for the active core: bit codes 0..6 word bits, 7 = l1_pdn
  logic [7:0] prevw [4];
  always @(negedge clk) begin
    for (int n = 0; n < 4; n++) begin
      logic [7:0] cur;
      cur = {l1_pdn[n], core_ctl[n*7 +: 7]};
      if (rst_n && n == act) begin
        for (int b = 0; b < 8; b++) if (cur[b] != prevw[n][b]) begin
          evlog = {evlog[27:0], 4'(b)};
          evn = evn + 1;
          if (b == 2 && cur[b]) t_p1 = cyc;
          if (b == 3 && cur[b]) t_p2 = cyc;
        end
      end
      prevw[n] = cur;
    end
  end

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, actv, expv);
    end
  endtask

  task automatic check_all(input string tag);
    for (int n = 0; n < 4; n++) begin
      chk(core_ctl[n*7 +: 7] == exp_w[n], tag, int'(core_ctl[n*7 +: 7]), int'(exp_w[n]));
      chk(l1_pdn[n] == exp_l[n], tag, int'(l1_pdn[n]), int'(exp_l[n]));
    end
  endtask

  task automatic wr_key(input logic [15:0] code, input logic en);
    @(negedge clk); key_wr = 1'b1; key_code = code; key_set = en;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic start_op(input int n, input bit on, input bit wi);
    @(negedge clk);
    act = n; req_valid = 1'b1; req_core = 2'(n); req_on = on; req_wait_idle = wi;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic finish_op(output bit gd, output bit ge, output int tend);
    int k = 0;
    while (!(done || err) && k < 3000) begin @(negedge clk); k++; end
    chk(k < 3000, "R11 sequence ends", k, 3000);
    gd = done; ge = err; tend = cyc;
    chk(!busy, "R11 busy low at end", int'(busy), 0);
    @(negedge clk);
    chk(!done && !err, "R11 single-cycle end pulse", int'({done, err}), 0);
  endtask

  task automatic run_op(input int n, input bit on, input bit wi, input bit exp_err,
                        input string tag, output int tend);
    bit gd, ge;
    start_op(n, on, wi);
    chk(busy, "R11 busy after accept", int'(busy), 1);
    finish_op(gd, ge, tend);
    chk(gd == !exp_err && ge == exp_err, tag, int'({gd, ge}), int'({!exp_err, exp_err}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int te, e0;
    process::self().srandom(32'h5eed_1234);
    for (int n = 0; n < 4; n++) begin exp_w[n] = 7'h32; exp_l[n] = 1'b1; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset word");
    chk(!busy && !done && !err, "R1 reset flags", int'({busy, done, err}), 0);

    // R2: locked, wrong key, right key with enable bit clear
    start_op(0, 1, 0); repeat (3) @(negedge clk);
    chk(!busy, "R2 locked request ignored", int'(busy), 0);
    wr_key(16'h0B17, 1'b1); start_op(0, 1, 0); repeat (3) @(negedge clk);
    chk(!busy, "R2 wrong key ignored", int'(busy), 0);
    wr_key(16'h0B16, 1'b0); start_op(0, 1, 0); repeat (3) @(negedge clk);
    chk(!busy, "R2 enable bit clear ignored", int'(busy), 0);
    check_all("R2 outputs unchanged");
    wr_key(16'h0B16, 1'b1);

    // R3 R4: clean power-up of core 1
    lat = 3; e0 = evn;
    run_op(1, 1, 0, 0, "R3 power-up done", te);
    exp_w[1] = 7'h4D; exp_l[1] = 1'b0;
    check_all("R3 final word");
    chk(evn - e0 == 8, "R3 one change per step", evn - e0, 8);
    chk(evlog == 32'h23176540, "R3 order", int'(evlog), 32'h23176540);
    chk(t_p2 - t_p1 == US + 1, "R4 switch gap", t_p2 - t_p1, US + 1);

    // R6: clean power-down of core 1
    e0 = evn;
    run_op(1, 0, 0, 0, "R6 power-down done", te);
    exp_w[1] = 7'h32; exp_l[1] = 1'b1;
    check_all("R6 final word");
    chk(evn - e0 == 8, "R6 one change per step", evn - e0, 8);
    chk(evlog == 32'h15670423, "R6 order", int'(evlog), 32'h15670423);

    // R10: request for another core while busy is ignored
    start_op(2, 1, 0);
    repeat (4) @(negedge clk);
    start_op(0, 1, 0);
    act = 2;
    begin bit gd, ge; finish_op(gd, ge, te); chk(gd, "R10 first op done", int'(gd), 1); end
    exp_w[2] = 7'h4D; exp_l[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R10 busy request dropped", int'(busy), 0);
    check_all("R10 other cores untouched");

    // R5 R8: secondary ack stuck low on core 0 power-up
    stk2 = 1;
    run_op(0, 1, 0, 1, "R5 single ack not enough", te);
    exp_w[0] = 7'h3E;
    check_all("R8 outputs held at timeout");
    chk(te - t_p2 == TMO, "R8 timeout window", te - t_p2, TMO);
    stk2 = 0;
    run_op(0, 0, 0, 0, "R5 recovery power-down", te);
    exp_w[0] = 7'h32;
    check_all("R5 recovery word");

    // R7 R8: L1 ack stuck low during power-down of core 2
    stkl = 1;
    run_op(2, 0, 0, 1, "R7 L1 ack missing on power-down", te);
    exp_w[2] = 7'h2F; exp_l[2] = 1'b1;
    check_all("R7 held at L1 wait");
    stkl = 0; repeat (8) @(negedge clk);
    run_op(2, 0, 0, 0, "R7 recovery power-down", te);
    exp_w[2] = 7'h32;
    check_all("R7 recovery word");

    // R7: L1 ack stuck high during power-up of core 3
    stkl = 1;
    run_op(3, 1, 0, 1, "R7 L1 ack stuck on power-up", te);
    exp_w[3] = 7'h3C; exp_l[3] = 1'b0;
    check_all("R7 held at L1 release");
    stkl = 0; repeat (8) @(negedge clk);
    run_op(3, 1, 0, 0, "R7 recovery power-up", te);
    exp_w[3] = 7'h4D;
    check_all("R7 recovery up word");

    // R9: wait-for-idle
    idle = 4'b0000;
    e0 = evn;
    run_op(3, 0, 1, 1, "R9 idle timeout", te);
    chk(evn == e0, "R9 no control change", evn - e0, 0);
    check_all("R9 outputs unchanged");
    idle = 4'b1000;
    run_op(3, 0, 1, 0, "R9 idle present", te);
    exp_w[3] = 7'h32; exp_l[3] = 1'b1;
    check_all("R9 power-down word");

    // R8: slow but in-window acks succeed
    lat = 70;
    run_op(1, 1, 0, 0, "R8 late ack accepted", te);
    exp_w[1] = 7'h4D; exp_l[1] = 1'b0;
    check_all("R8 late ack word");

    // R2: enable cleared again, then restored
    wr_key(16'h1234, 1'b1); start_op(2, 1, 0); repeat (3) @(negedge clk);
    chk(!busy, "R2 cleared enable", int'(busy), 0);
    wr_key(16'h0B16, 1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n; bit on, wi, xerr; logic [7:0] st0;
      n = $urandom_range(0, 3); on = 1'($urandom); wi = 1'($urandom);
      lat = $urandom_range(0, 30); idle = 4'($urandom);
      xerr = !on && wi && !idle[n];
      st0 = {exp_l[n], exp_w[n]};
      e0 = evn;
      run_op(n, on, wi, xerr, on ? "R3 random power-up" : "R6 random power-down", te);
      if (!xerr) begin exp_w[n] = on ? 7'h4D : 7'h32; exp_l[n] = !on; end
      check_all(xerr ? "R9 random idle timeout" : "R10 random words");
      if (on && st0 == 8'hB2)
        chk(evlog == 32'h23176540 && evn - e0 == 8, "R3 random order", int'(evlog), 32'h23176540);
      if (!on && !xerr && st0 == 8'h4D)
        chk(evlog == 32'h15670423 && evn - e0 == 8, "R6 random order", int'(evlog), 32'h15670423);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule